// File: doc/BRIEF.md
# Serial Transmitter with Software Line Override

This block is the transmit half of an asynchronous serial port. Bytes are written into a small transmit queue and sent one frame at a time. A frame is a low start bit, eight data bits with the least significant first, an optional parity bit and one high stop bit. Each bit lasts one period of an external baud tick. Two flags report the queue state: a low-water flag and a transmission-done flag.

A transmit-enable input, `txEnable`, decides who owns the output pin. While it is high, the serial engine drives the pin and the software pin controls are ignored. While it is low, the pin direction comes from `portDirOut` and the pin level from `portLevel`. Software uses this to hold the line at mark level before enabling, or to float it. Dropping `txEnable` aborts a frame in progress at once, so the same two controls can then hold the line low as a break.

The sequence for a break is to clear `portLevel` first and then clear `txEnable`. From the next cycle the pin drives a steady low.

Top module: `txline_unit`

## Requirements
- R1: During and directly after reset, with `txEnable` low, `doneFlag` and `fifoLowFlag` are 1 and the pin follows `portDirOut`/`portLevel`.
- R2: While `txEnable` is 0, `txdOe` equals `portDirOut` and `txdOut` equals `portLevel` in the same cycle, including the first cycle after `txEnable` drops.
- R3: While `txEnable` is 1, `txdOe` is 1 and `portDirOut`/`portLevel` have no effect. With no frame in progress, `txdOut` is 1.
- R4: A frame starts at the clock edge that closes a cycle in which `baudTick` is high, no frame is in progress and the queue is not empty. It is sent as bit 0 = start (0), bits 1..8 = data LSB first, then stop (1). Each bit holds for one tick period.
- R5: With `parityOn` = 1, a parity bit goes between the data and the stop bit. Its value is the XOR of the data bits, XORed with `parityOdd`.
- R6: The queue holds DEPTH (default 16) bytes. A write while the queue is full is dropped, and so is a write while `txEnable` is 0.
- R7: Clearing `txEnable` empties the queue and ends any frame at the next edge. After re-enable, the line idles high and no flushed byte is sent.
- R8: `fifoLowFlag` is 1 exactly when the number of queued bytes is less than or equal to `trigLevel`.
- R9: `doneFlag` is 1 exactly when the queue is empty and no frame is in progress. It rises at the edge that ends the last stop bit.
- R10: With `portDirOut` = 1 and `portLevel` = 0, clearing `txEnable` gives a continuous low output for as long as `txEnable` stays 0.
- R11: With `txEnable` = 0 and `portDirOut` = 0, `txdOe` is 0, so the pin is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse per bit period |
| wrData | input | 8 | Byte to queue |
| wrStrobe | input | 1 | Queue `wrData` this cycle |
| txEnable | input | 1 | Transmit enable; low aborts and flushes |
| parityOn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | Select odd parity |
| trigLevel | input | CNT_W (5) | Low-water threshold for `fifoLowFlag` |
| portDirOut | input | 1 | Pin direction while disabled (1 = drive) |
| portLevel | input | 1 | Pin level while disabled |
| txdOut | output | 1 | Serial line value |
| txdOe | output | 1 | Serial line output enable |
| fifoLowFlag | output | 1 | Queue at or below `trigLevel` |
| doneFlag | output | 1 | Queue empty and line idle |

## Verification
A queue pointer or count that goes wrong shows up on `fifoLowFlag` or `doneFlag` in the cycle after the bad update. It also shows up later as a wrong or missing frame on `txdOut`. A wrong bit counter or shift state shows on the line within one tick period, as a misplaced start, parity or stop bit. The bench rebuilds the expected line and flags every cycle, so such a fault is reported on the first clock where the pin or a flag differs.

// File: rtl/txline_pkg.sv
package txline_pkg;
  // Strobes from the sequencer to the datapath, at most a few per cycle.
  typedef struct packed {
    logic push;    // accept a byte into the queue
    logic load;    // pop head byte into the frame shifter, drive start bit
    logic shift;   // advance to the next frame bit
    logic finish;  // stop bit completed, return line to mark
    logic flush;   // transmitter disabled: clear queue and line state
  } txStrobe_t;
endpackage

// File: rtl/txline_ctrl.sv
module txline_ctrl
  import txline_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       wrStrobe,
  input  logic       baudTick,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  input  logic       parityOn,
  output txStrobe_t  strb,
  output logic       busy
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [LEFT_W-1:0] bitsLeft;
  logic              lastBit;

  assign lastBit = (bitsLeft == LEFT_W'(1));

  always_comb begin
    strb        = '0;
    strb.flush  = !txEnable;
    strb.push   = txEnable && wrStrobe && !fifoFull;
    strb.load   = txEnable && baudTick && !busy && !fifoEmpty;
    strb.shift  = txEnable && baudTick && busy && !lastBit;
    strb.finish = txEnable && baudTick && busy && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
    end else if (strb.load) begin
      busy     <= 1'b1;
      bitsLeft <= parityOn ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
    end else if (strb.shift) begin
      bitsLeft <= bitsLeft - LEFT_W'(1);
    end else if (strb.finish) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
    end
  end
endmodule

// File: rtl/txline_dp.sv
module txline_dp
  import txline_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              parityOn,
  input  logic              parityOdd,
  output logic              lineBit,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FRAME_W = DATA_W + 3;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [FRAME_W-1:0] frameQ, frameNew;
  logic [DATA_W-1:0]  headByte;
  logic               parBit;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign fifoFull  = (fifoCount == CNT_W'(DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign headByte  = mem[rdPtr];
  assign parBit    = (^headByte) ^ parityOdd;
  assign frameNew  = parityOn ? {1'b1, parBit, headByte, 1'b0}
                              : {1'b1, 1'b1, headByte, 1'b0};

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.load) rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.load})
        2'b10:   fifoCount <= fifoCount + CNT_W'(1);
        2'b01:   fifoCount <= fifoCount - CNT_W'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      frameQ  <= '1;
      lineBit <= 1'b1;
    end else if (strb.load) begin
      frameQ  <= frameNew;
      lineBit <= frameNew[0];
    end else if (strb.shift) begin
      frameQ  <= frameQ >> 1;
      lineBit <= frameQ[1];
    end else if (strb.finish) begin
      frameQ  <= '1;
      lineBit <= 1'b1;
    end
  end
endmodule

// File: rtl/txline_unit.sv
module txline_unit
  import txline_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              txEnable,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              portDirOut,
  input  logic              portLevel,
  output logic              txdOut,
  output logic              txdOe,
  output logic              fifoLowFlag,
  output logic              doneFlag
);
  txStrobe_t        strb;
  logic             busy;
  logic             lineBit;
  logic [CNT_W-1:0] fifoCount;
  logic             fifoFull, fifoEmpty;

  txline_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrStrobe(wrStrobe),
    .baudTick(baudTick), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .parityOn(parityOn), .strb(strb), .busy(busy)
  );

  txline_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .parityOn(parityOn), .parityOdd(parityOdd), .lineBit(lineBit),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  // Pin ownership: serial engine when enabled, software controls otherwise.
  assign txdOut      = txEnable ? lineBit : portLevel;
  assign txdOe       = txEnable | portDirOut;
  assign fifoLowFlag = (fifoCount <= trigLevel);
  assign doneFlag    = !busy && fifoEmpty;
endmodule

// File: rtl/txline_checks.sv
module txline_checks #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txEnable,
  input logic             txdOut,
  input logic             busy,
  input logic             doneFlag,
  input logic             fifoLowFlag,
  input logic [CNT_W-1:0] fifoCount
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) |=> doneFlag);

  assert_idle_mark_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && doneFlag) |-> txdOut);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $rose(busy)) |-> !txdOut);

  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && $fell(busy)) |-> txdOut);

  assert_done_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> fifoLowFlag);
endmodule

bind txline_unit txline_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .txdOut(txdOut),
  .busy(busy), .doneFlag(doneFlag), .fifoLowFlag(fifoLowFlag),
  .fifoCount(fifoCount)
);

// File: tb/txline_unit_bench.sv
`timescale 1ns/1ps
module txline_unit_bench;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0;
  always #2 clk = ~clk;  // 250 MHz

  logic rstN = 0, baudTick = 0, wrStrobe = 0, txEnable = 0;
  logic parityOn = 0, parityOdd = 0, portDirOut = 1, portLevel = 1;
  logic [7:0] wrData = 0;
  logic [CNT_W-1:0] trigLevel = 4;
  logic txdOut, txdOe, fifoLowFlag, doneFlag;

  txline_unit u_txline_unit (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrData(wrData),
    .wrStrobe(wrStrobe), .txEnable(txEnable), .parityOn(parityOn),
    .parityOdd(parityOdd), .trigLevel(trigLevel), .portDirOut(portDirOut),
    .portLevel(portLevel), .txdOut(txdOut), .txdOe(txdOe),
    .fifoLowFlag(fifoLowFlag), .doneFlag(doneFlag)
  );

  int runs = 0, fails = 0;
  bit cmpOn = 0, tickOn = 1, finished = 0;
  int tickCnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of bytes plus a list of pending line bits.
  logic [7:0] q[$];
  bit mLine[$];      // remaining bits of current frame, head is on the line
  bit mCur = 1;
  int mHold = 0;     // 1 while a frame is in progress

  always @(posedge clk) begin
    if (!rstN || !txEnable) begin
      q.delete(); mLine.delete(); mCur = 1; mHold = 0;
    end else begin
      bit doStart, doPush;
      doStart = baudTick && (mHold == 0) && (q.size() > 0);
      doPush  = wrStrobe && (q.size() < DEPTH);
      if (baudTick && mHold != 0) begin
        void'(mLine.pop_front());
        if (mLine.size() == 0) begin mHold = 0; mCur = 1; end
        else mCur = mLine[0];
      end
      if (doStart) begin
        logic [7:0] b;
        b = q.pop_front();
        mLine.push_back(0);
        for (int i = 0; i < 8; i++) mLine.push_back(b[i]);
        if (parityOn) mLine.push_back((^b) ^ parityOdd);
        mLine.push_back(1);
        mCur = 0; mHold = 1;
      end
      if (doPush) q.push_back(wrData);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      bit eTx, eOe, eDone, eLow;
      eTx   = txEnable ? mCur : portLevel;
      eOe   = txEnable ? 1'b1 : portDirOut;
      eDone = (mHold == 0) && (q.size() == 0);
      eLow  = q.size() <= trigLevel;
      chk(txdOut == eTx, "R4 line value", txdOut, eTx);
      chk(txdOe == eOe, "R2 output enable", txdOe, eOe);
      chk(doneFlag == eDone, "R9 done flag", doneFlag, eDone);
      chk(fifoLowFlag == eLow, "R8 low flag", fifoLowFlag, eLow);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    tickCnt++;
    baudTick = tickOn && (tickCnt % 4 == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put(input logic [7:0] b);
    wrData = b; wrStrobe = 1; cyc(); wrStrobe = 0;
  endtask

  task automatic frameCheck(input logic [7:0] b, input bit pOn, input bit pOdd);
    int guard = 0;
    @(negedge clk);
    while (txdOut !== 1'b0 && guard < 400) begin cyc(); @(negedge clk); guard++; end
    chk(guard < 400, "R4 frame start seen", guard, 0);
    cyc(); cyc(); @(negedge clk);
    chk(txdOut == 0, "R4 start bit", txdOut, 0);
    for (int k = 0; k < 8; k++) begin
      run(4); @(negedge clk);
      chk(txdOut == b[k], "R4 data bit LSB first", txdOut, b[k]);
    end
    if (pOn) begin
      run(4); @(negedge clk);
      chk(txdOut == ((^b) ^ pOdd), "R5 parity bit", txdOut, (^b) ^ pOdd);
    end
    run(4); @(negedge clk);
    chk(txdOut == 1, "R4 stop bit", txdOut, 1);
  endtask

  task automatic waitDone();
    int g = 0;
    while (!doneFlag && g < 2000) begin cyc(); g++; end
    run(8);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      fails++; runs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    run(3);
    @(negedge clk);
    chk(txdOe == 1 && txdOut == 1, "R1 pin follows port in reset", {txdOe, txdOut}, 3);
    chk(doneFlag == 1 && fifoLowFlag == 1, "R1 flags in reset", {doneFlag, fifoLowFlag}, 3);
    rstN = 1; cyc(); cmpOn = 1;

    // R11 high impedance, R2 following port level
    portDirOut = 0; portLevel = 0; cyc(); @(negedge clk);
    chk(txdOe == 0, "R11 floated pin", txdOe, 0);
    chk(txdOut == 0, "R2 level follows port", txdOut, 0);
    portDirOut = 1; portLevel = 1; cyc();

    // R6 writes while disabled are dropped
    put(8'h11); put(8'h22);
    txEnable = 1; run(80); @(negedge clk);
    chk(doneFlag == 1 && txdOut == 1, "R6 write while disabled dropped", {doneFlag, txdOut}, 3);

    // R3 port inputs ignored while enabled
    portDirOut = 0; portLevel = 0; cyc(); @(negedge clk);
    chk(txdOe == 1 && txdOut == 1, "R3 port controls ignored", {txdOe, txdOut}, 3);
    portDirOut = 1; portLevel = 1;

    // R4 frames, no parity
    put(8'hA5); frameCheck(8'hA5, 0, 0);
    put(8'h3C); put(8'h81); waitDone();
    // R5 parity even and odd
    parityOn = 1; parityOdd = 0; put(8'h5B); frameCheck(8'h5B, 1, 0); waitDone();
    parityOdd = 1; put(8'h5B); frameCheck(8'h5B, 1, 1); waitDone();
    put(8'h00); waitDone();
    parityOn = 0;

    // R6 overflow with frozen ticks, R8 thresholds
    tickOn = 0; baudTick = 0;
    for (int i = 0; i < 20; i++) put(8'(i * 7 + 3));
    trigLevel = 16; cyc(); @(negedge clk);
    chk(fifoLowFlag == 1, "R8 count at threshold", fifoLowFlag, 1);
    trigLevel = 15; cyc(); @(negedge clk);
    chk(fifoLowFlag == 0, "R6 queue holds exactly DEPTH", fifoLowFlag, 0);
    trigLevel = 4;
    tickOn = 1; run(90);

    // R7 abort mid-frame
    txEnable = 0; @(negedge clk);
    chk(txdOut == portLevel, "R2 pin released on disable", txdOut, portLevel);
    cyc(); @(negedge clk);
    chk(doneFlag == 1 && fifoLowFlag == 1, "R7 flush on disable", {doneFlag, fifoLowFlag}, 3);
    txEnable = 1; bad = 0;
    for (int i = 0; i < 120; i++) begin cyc(); @(negedge clk); if (txdOut != 1) bad++; end
    chk(bad == 0, "R7 nothing sent after re-enable", bad, 0);
    put(8'hC3); frameCheck(8'hC3, 0, 0); waitDone();

    // R10 break
    portLevel = 0; cyc(); @(negedge clk);
    chk(txdOut == 1, "R3 level ignored while enabled", txdOut, 1);
    put(8'hF0); run(10);
    txEnable = 0; bad = 0;
    for (int i = 0; i < 40; i++) begin cyc(); @(negedge clk); if (txdOut != 0 || txdOe != 1) bad++; end
    chk(bad == 0, "R10 continuous break low", bad, 0);
    portLevel = 1; cyc(); @(negedge clk);
    chk(txdOut == 1, "R9 mark restored", txdOut, 1);
    chk(doneFlag == 1, "R9 done after flush", doneFlag, 1);

    cmpOn = 0; finished = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule